// File: doc/BRIEF.md
# Dual-Counter Real-Time Clock Core with Subsecond and Seconds Alarms

This block keeps time from a 32768 Hz slow clock. A 15-bit subsecond counter advances once per slow tick and wraps to zero after its all-ones value. That wrap produces a carry into a 32-bit seconds counter. The carry is registered, so the seconds counter moves one slow cycle after the subsecond counter has reached zero. Each counter has its own run bit, a preload register, an alarm value, an interrupt enable and a sticky flag. Each alarm either fires on a value match or fires on every increment of its counter.

Software reaches the block through a simple write/read port on a faster bus clock. A write to any register that the slow domain consumes is carried across by a toggle handshake, with two flops in each direction. While that handshake is in flight the register's own busy bit is set. A further write to the same register is dropped until its busy bit clears. Flags are cleared by writing ones to a clear register. The flags and the combined interrupt are synchronised back into the bus domain. The two counters are also presented directly as slow-domain outputs.

Top module: `rtc_core`

## Requirements
- R1: After reset both counters read 0, every control field is 0, the status word (address 6) reads 0 and `irq_o` is low.
- R2: Control bit 0 is the subsecond run bit. When it is set, the subsecond counter increases by one on each slow clock edge and goes from 32767 to 0. When it is clear, the counter holds its value.
- R3: The seconds counter increases by one on the slow edge that follows the edge on which the subsecond counter wrapped to 0. For exactly one slow cycle the outputs therefore show 0 subseconds with the old seconds value.
- R4: Control bit 1 is the seconds run bit. When it is clear, the seconds counter keeps its value even when the subsecond counter wraps.
- R5: A value written to address 3 (subsecond preload) or address 4 (seconds preload) is placed into that counter when the slow domain takes the write. A control write with bit 6 set zeroes both counters.
- R6: Addresses 1 and 2 hold the subsecond and seconds alarm values. In match mode a counter equal to its alarm sets its sticky flag, but only while that flag's enable is set. Control bit 2 is the subsecond enable and bit 3 is the seconds enable.
- R7: Control bits 4 (subsecond) and 5 (seconds) select increment mode. In that mode an enabled flag is set on every slow cycle in which its counter advances, and never while the counter is stopped.
- R8: Writing to address 5 clears flags: bit 0 clears the subsecond flag and bit 1 clears the seconds flag. If a set condition occurs in the same slow cycle as the clear, the flag stays set.
- R9: `irq_o` is the OR of each flag ANDed with its enable, carried into the bus clock domain. A flag whose enable has been removed stays set in status bits 8 (subsecond) and 9 (seconds) but no longer drives `irq_o`.
- R10: Each slow-domain write sets its status busy bit in the next bus cycle. The bits are: 0 control, 1 subsecond alarm, 2 seconds alarm, 3 subsecond preload, 4 seconds preload, 5 subsecond clear, 6 seconds clear. The bit clears two bus cycles after the third slow rising edge that follows the write.
- R11: Status bit 7 is set while any busy bit is set.
- R12: A write to a register whose busy bit is set is dropped. It changes neither the readback nor the slow domain.
- R13: Addresses 0 to 4 read back the last accepted write. Address 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Bus clock for the register port |
| slow_clk_i | input | 1 | 32768 Hz counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_en_i | input | 1 | Write strobe, one bus cycle per write |
| addr_i | input | 3 | Register address for writes and reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request in the bus domain |
| sub_cnt_o | output | 15 | Subsecond counter, slow domain |
| sec_cnt_o | output | 32 | Seconds counter, slow domain |

## Verification
A flag's set condition and a software clear can land in the same slow cycle. The flag logic resolves this by letting the set win. The bench provokes the collision twice. The first time, it clears the subsecond flag while that counter runs in increment mode, so a set is present on every edge. The second time, it clears the seconds flag while the stopped seconds counter sits on its alarm in match mode. In both cases, once the clear's busy bit has dropped, the flag must still read set. After the set source is removed, a second clear must bring the flag to zero. The seconds carry and the subsecond wrap fall on adjacent slow edges. The scoreboard stream checks that sequence edge by edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // data-carrying slow-domain registers (index also the status busy bit)
    localparam int CH_CTRL    = 0;
    localparam int CH_SUB_ALM = 1;
    localparam int CH_SEC_ALM = 2;
    localparam int CH_SUB_LD  = 3;
    localparam int CH_SEC_LD  = 4;
    localparam int NDATA      = 5;
    // one-bit clear requests follow the data channels in the status word
    localparam int NCLR       = 2;
    localparam int NCH        = NDATA + NCLR;

    typedef enum logic [2:0] {
        A_CTRL    = 3'd0,
        A_SUB_ALM = 3'd1,
        A_SEC_ALM = 3'd2,
        A_SUB_LD  = 3'd3,
        A_SEC_LD  = 3'd4,
        A_CLR     = 3'd5,
        A_STAT    = 3'd6
    } addr_e;

    // control word bit positions
    localparam int CB_SUB_RUN  = 0;
    localparam int CB_SEC_RUN  = 1;
    localparam int CB_SUB_IE   = 2;
    localparam int CB_SEC_IE   = 3;
    localparam int CB_SUB_MODE = 4;
    localparam int CB_SEC_MODE = 5;
    localparam int CB_ZERO     = 6;
    localparam int CTRL_W      = 7;

    typedef struct packed {
        logic sub_run;
        logic sec_run;
        logic sub_ie;
        logic sec_ie;
        logic sub_inc_mode;
        logic sec_inc_mode;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.sub_run      = w[CB_SUB_RUN];
        c.sec_run      = w[CB_SEC_RUN];
        c.sub_ie       = w[CB_SUB_IE];
        c.sec_ie       = w[CB_SEC_IE];
        c.sub_inc_mode = w[CB_SUB_MODE];
        c.sec_inc_mode = w[CB_SEC_MODE];
        return c;
    endfunction

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= stage_d;
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rtc_xfer.sv
module rtc_xfer #(
    parameter int W = 32
) (
    input  logic         bus_clk_i,
    input  logic         slow_clk_i,
    input  logic         rst_ni,
    input  logic         launch_i,
    input  logic [W-1:0] data_i,
    output logic         busy_o,
    output logic [W-1:0] hold_o,
    output logic         take_o
);
    typedef struct packed {
        logic         req;
        logic [W-1:0] hold;
    } bus_t;

    bus_t bus_d, bus_q;
    logic seen_d, seen_q;
    logic req_slow, ack_bus;

    // bus side: toggle request and capture the payload
    always_comb begin
        bus_d = bus_q;
        if (launch_i) begin
            bus_d.req  = ~bus_q.req;
            bus_d.hold = data_i;
        end
    end

    always_ff @(posedge bus_clk_i or negedge rst_ni) begin
        if (!rst_ni) bus_q <= '0;
        else         bus_q <= bus_d;
    end

    rtc_sync #(.W(1), .STAGES(2)) u_req_sync (
        .clk_i (slow_clk_i),
        .rst_ni(rst_ni),
        .d_i   (bus_q.req),
        .q_o   (req_slow)
    );

    // slow side: edge of the synchronised toggle is the take pulse
    always_comb begin
        seen_d = req_slow;
    end

    always_ff @(posedge slow_clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= seen_d;
    end

    rtc_sync #(.W(1), .STAGES(2)) u_ack_sync (
        .clk_i (bus_clk_i),
        .rst_ni(rst_ni),
        .d_i   (seen_q),
        .q_o   (ack_bus)
    );

    assign take_o = req_slow ^ seen_q;
    assign busy_o = bus_q.req ^ ack_bus;
    assign hold_o = bus_q.hold;
endmodule

// File: rtl/rtc_slow.sv
module rtc_slow
    import rtc_pkg::*;
#(
    parameter int SUB_W = 15,
    parameter int SEC_W = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NCH-1:0]      take_i,
    input  logic [CTRL_W-1:0]   ctrl_i,
    input  logic [SUB_W-1:0]    sub_alm_i,
    input  logic [SEC_W-1:0]    sec_alm_i,
    input  logic [SUB_W-1:0]    sub_ld_i,
    input  logic [SEC_W-1:0]    sec_ld_i,
    input  logic [NCLR-1:0]     clr_i,
    output logic [SUB_W-1:0]    sub_cnt_o,
    output logic [SEC_W-1:0]    sec_cnt_o,
    output logic                sub_flag_o,
    output logic                sec_flag_o,
    output logic                sub_run_o,
    output logic                sec_run_o,
    output logic                irq_o
);
    localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

    typedef struct packed {
        ctrl_t            ctrl;
        logic [SUB_W-1:0] sub;
        logic [SEC_W-1:0] sec;
        logic             carry;
        logic [SUB_W-1:0] sub_alm;
        logic [SEC_W-1:0] sec_alm;
        logic             sub_flag;
        logic             sec_flag;
        logic             irq;
    } slow_t;

    slow_t st_d, st_q;

    logic sub_step, sec_step, sub_wrap, sub_hit, sec_hit;
    logic zero_req;

    always_comb begin
        st_d = st_q;

        sub_step = st_q.ctrl.sub_run;
        sec_step = st_q.carry && st_q.ctrl.sec_run;
        sub_wrap = sub_step && (st_q.sub == SUB_MAX);

        // counting
        if (sub_step) st_d.sub = sub_wrap ? '0 : st_q.sub + 1'b1;
        if (sec_step) st_d.sec = st_q.sec + 1'b1;
        st_d.carry = sub_wrap && !take_i[CH_SUB_LD];

        // preloads override counting
        if (take_i[CH_SUB_LD]) st_d.sub = sub_ld_i;
        if (take_i[CH_SEC_LD]) st_d.sec = sec_ld_i;

        // control update, with the zeroing request overriding everything
        zero_req = take_i[CH_CTRL] && ctrl_i[CB_ZERO];
        if (take_i[CH_CTRL]) st_d.ctrl = decode_ctrl(ctrl_i);
        if (zero_req) begin
            st_d.sub   = '0;
            st_d.sec   = '0;
            st_d.carry = 1'b0;
        end

        if (take_i[CH_SUB_ALM]) st_d.sub_alm = sub_alm_i;
        if (take_i[CH_SEC_ALM]) st_d.sec_alm = sec_alm_i;

        // alarm events from the present state
        sub_hit = st_q.ctrl.sub_ie &&
                  (st_q.ctrl.sub_inc_mode ? sub_step : (st_q.sub == st_q.sub_alm));
        sec_hit = st_q.ctrl.sec_ie &&
                  (st_q.ctrl.sec_inc_mode ? sec_step : (st_q.sec == st_q.sec_alm));

        // clear first, a set event in the same cycle wins
        if (take_i[NDATA + 0] && clr_i[0]) st_d.sub_flag = 1'b0;
        if (take_i[NDATA + 1] && clr_i[1]) st_d.sec_flag = 1'b0;
        if (sub_hit) st_d.sub_flag = 1'b1;
        if (sec_hit) st_d.sec_flag = 1'b1;

        st_d.irq = (st_d.sub_flag && st_d.ctrl.sub_ie) ||
                   (st_d.sec_flag && st_d.ctrl.sec_ie);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sub_cnt_o  = st_q.sub;
    assign sec_cnt_o  = st_q.sec;
    assign sub_flag_o = st_q.sub_flag;
    assign sec_flag_o = st_q.sec_flag;
    assign sub_run_o  = st_q.ctrl.sub_run;
    assign sec_run_o  = st_q.ctrl.sec_run;
    assign irq_o      = st_q.irq;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int SUB_W  = 15,
    parameter int SEC_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              bus_clk_i,
    input  logic              slow_clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic [SUB_W-1:0]  sub_cnt_o,
    output logic [SEC_W-1:0]  sec_cnt_o
);
    localparam int STAT_ANY  = NCH;
    localparam int STAT_FSUB = NCH + 1;
    localparam int STAT_FSEC = NCH + 2;

    logic [NCH-1:0]               launch;
    logic [NCH-1:0]               busy;
    logic [NCH-1:0]               take;
    logic [NDATA-1:0][DATA_W-1:0] hold;
    logic [NCLR-1:0]              clr_hold;
    logic [DATA_W-1:0]            status;

    logic sub_flag_s, sec_flag_s, sub_run_s, sec_run_s, irq_s;
    logic [2:0] back_sync;

    // bus-side launch decode: writes to a busy register are dropped
    always_comb begin
        launch = '0;
        for (int ch = 0; ch < NDATA; ch++) begin
            launch[ch] = wr_en_i && (addr_i == 3'(ch)) && !busy[ch];
        end
        for (int k = 0; k < NCLR; k++) begin
            launch[NDATA + k] = wr_en_i && (addr_i == A_CLR) &&
                                wdata_i[k] && !busy[NDATA + k];
        end
    end

    for (genvar ch = 0; ch < NDATA; ch++) begin : g_data
        rtc_xfer #(.W(DATA_W)) u_xfer (
            .bus_clk_i (bus_clk_i),
            .slow_clk_i(slow_clk_i),
            .rst_ni    (rst_ni),
            .launch_i  (launch[ch]),
            .data_i    (wdata_i),
            .busy_o    (busy[ch]),
            .hold_o    (hold[ch]),
            .take_o    (take[ch])
        );
    end

    for (genvar k = 0; k < NCLR; k++) begin : g_clr
        rtc_xfer #(.W(1)) u_xfer (
            .bus_clk_i (bus_clk_i),
            .slow_clk_i(slow_clk_i),
            .rst_ni    (rst_ni),
            .launch_i  (launch[NDATA + k]),
            .data_i    (wdata_i[k]),
            .busy_o    (busy[NDATA + k]),
            .hold_o    (clr_hold[k]),
            .take_o    (take[NDATA + k])
        );
    end

    rtc_slow #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_slow (
        .clk_i     (slow_clk_i),
        .rst_ni    (rst_ni),
        .take_i    (take),
        .ctrl_i    (hold[CH_CTRL][CTRL_W-1:0]),
        .sub_alm_i (hold[CH_SUB_ALM][SUB_W-1:0]),
        .sec_alm_i (hold[CH_SEC_ALM][SEC_W-1:0]),
        .sub_ld_i  (hold[CH_SUB_LD][SUB_W-1:0]),
        .sec_ld_i  (hold[CH_SEC_LD][SEC_W-1:0]),
        .clr_i     (clr_hold),
        .sub_cnt_o (sub_cnt_o),
        .sec_cnt_o (sec_cnt_o),
        .sub_flag_o(sub_flag_s),
        .sec_flag_o(sec_flag_s),
        .sub_run_o (sub_run_s),
        .sec_run_o (sec_run_s),
        .irq_o     (irq_s)
    );

    rtc_sync #(.W(3), .STAGES(2)) u_back_sync (
        .clk_i (bus_clk_i),
        .rst_ni(rst_ni),
        .d_i   ({sec_flag_s, sub_flag_s, irq_s}),
        .q_o   (back_sync)
    );

    assign irq_o = back_sync[0];

    // read path
    always_comb begin
        status            = '0;
        status[NCH-1:0]   = busy;
        status[STAT_ANY]  = |busy;
        status[STAT_FSUB] = back_sync[1];
        status[STAT_FSEC] = back_sync[2];
        case (addr_i)
            A_CTRL, A_SUB_ALM, A_SEC_ALM, A_SUB_LD, A_SEC_LD:
                     rdata_o = hold[addr_i];
            A_STAT:  rdata_o = status;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_pkg::*;
#(
    parameter int SUB_W  = 15,
    parameter int SEC_W  = 32,
    parameter int DATA_W = 32
) (
    input logic              bus_clk,
    input logic              slow_clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [NCH-1:0]    launch,
    input logic [NCH-1:0]    busy,
    input logic [NCH-1:0]    take,
    input logic [DATA_W-1:0] ctrl_hold,
    input logic [SUB_W-1:0]  sub_cnt,
    input logic [SEC_W-1:0]  sec_cnt,
    input logic              sub_run,
    input logic              sec_run,
    input logic              sub_flag,
    input logic              sec_flag
);
    localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

    // R10: an accepted write raises its busy bit in the next bus cycle
    a_r10_busy_follows_launch: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        (launch != '0) |=> ((busy & $past(launch)) == $past(launch)));

    // R12: a control write during busy leaves the held value unchanged
    a_r12_busy_write_dropped: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && busy[CH_CTRL]) |=> $stable(ctrl_hold));

    // R2: a running subsecond counter at its top value goes to zero
    a_r2_sub_wraps: assert property (
        @(posedge slow_clk) disable iff (!rst_n)
        (sub_run && sub_cnt == SUB_MAX && take == '0) |=> (sub_cnt == '0));

    // R3: seconds move only right after the subsecond counter showed zero
    a_r3_sec_after_zero: assert property (
        @(posedge slow_clk) disable iff (!rst_n)
        (sec_cnt != $past(sec_cnt) && !$past(take[CH_SEC_LD]) && !$past(take[CH_CTRL]))
        |-> ($past(sub_cnt) == '0));

    // R4: with seconds stopped and no control or preload write, seconds hold
    a_r4_sec_frozen: assert property (
        @(posedge slow_clk) disable iff (!rst_n)
        (!sec_run && !take[CH_SEC_LD] && !take[CH_CTRL]) |=> $stable(sec_cnt));

    // R8: flags only fall after their clear write is taken
    a_r8_sub_flag_fall: assert property (
        @(posedge slow_clk) disable iff (!rst_n)
        $fell(sub_flag) |-> $past(take[NDATA + 0]));

    a_r8_sec_flag_fall: assert property (
        @(posedge slow_clk) disable iff (!rst_n)
        $fell(sec_flag) |-> $past(take[NDATA + 1]));
endmodule

bind rtc_core rtc_core_chk #(.SUB_W(SUB_W), .SEC_W(SEC_W), .DATA_W(DATA_W)) u_chk (
    .bus_clk  (bus_clk_i),
    .slow_clk (slow_clk_i),
    .rst_n    (rst_ni),
    .wr_en    (wr_en_i),
    .addr     (addr_i),
    .launch   (launch),
    .busy     (busy),
    .take     (take),
    .ctrl_hold(hold[rtc_pkg::CH_CTRL]),
    .sub_cnt  (sub_cnt_o),
    .sec_cnt  (sec_cnt_o),
    .sub_run  (sub_run_s),
    .sec_run  (sec_run_s),
    .sub_flag (sub_flag_s),
    .sec_flag (sec_flag_s)
);

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
    localparam int SUB_MAX = 32767;

    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [14:0] sub_cnt;
    logic [31:0] sec_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int slow_edges = 0;

    typedef struct {
        int unsigned sub;
        int unsigned sec;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    rtc_core u_dut (
        .bus_clk_i (bus_clk),
        .slow_clk_i(slow_clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_o     (irq),
        .sub_cnt_o (sub_cnt),
        .sec_cnt_o (sec_cnt)
    );

    // 200 MHz bus clock; slow clock offset so edges never coincide
    always #2.5 bus_clk = ~bus_clk;
    initial begin
        #1;
        forever #40 slow_clk = ~slow_clk;
    end
    always @(posedge slow_clk) slow_edges <= slow_edges + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares counters against queued predictions
    always @(negedge slow_clk) begin
        exp_t e;
        if (sb_q.size() != 0) begin
            e = sb_q.pop_front();
            check({e.req, " sub"}, 32'(sub_cnt), e.sub);
            check({e.req, " sec"}, sec_cnt, e.sec);
        end
    end

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wr_raw(input logic [2:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int guard = 0;
        do begin
            rd(3'd6, s);
            guard++;
        end while (s[7] && guard < 400);
    endtask

    // write, then check busy assertion and its release latency (R10)
    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [6:0] mask);
        int e0;
        int guard = 0;
        @(negedge bus_clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge bus_clk);
        e0 = slow_edges;
        @(negedge bus_clk);
        wr_en = 1'b0;
        addr = 3'd6;
        #1 check("R10 busy set", 32'(rdata[6:0] & mask), 32'(mask));
        while ((rdata[6:0] & mask) != 0 && guard < 400) begin
            @(negedge bus_clk);
            #1 guard++;
        end
        check("R10 release edges", slow_edges - e0, 3);
    endtask

    task automatic wait_slow(input int n);
        repeat (n) @(negedge slow_clk);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] s;
        int unsigned ms, mc;
        logic pend;

        repeat (5) @(negedge bus_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge bus_clk);

        // R1 reset state
        check("R1 sub", 32'(sub_cnt), 0);
        check("R1 sec", sec_cnt, 0);
        check("R1 irq", 32'(irq), 0);
        rd(3'd6, s); check("R1 status", s, 0);
        rd(3'd0, s); check("R1 ctrl", s, 0);

        // R5 preloads with counters stopped, R13 readback
        wr(3'd3, 32760, 7'b0001000);
        wr(3'd4, 5, 7'b0010000);
        rd(3'd3, s); check("R13 sub preload readback", s, 32760);
        rd(3'd5, s); check("R13 clear reads zero", s, 0);
        wait_slow(1);
        check("R5 sub preload", 32'(sub_cnt), 32760);
        check("R5 sec preload", sec_cnt, 5);
        wait_slow(3);
        check("R2 stopped sub", 32'(sub_cnt), 32760);

        // R12 dropped write and R11 any-busy
        wr_raw(3'd0, 32'h3);
        wr_raw(3'd0, 32'h0);
        rd(3'd6, s); check("R11 any busy", 32'(s[7]), 1);
        wait_idle();
        rd(3'd6, s); check("R11 any busy clear", 32'(s[7]), 0);
        rd(3'd0, s); check("R12 dropped write", s, 32'h3);

        // R2/R3 scoreboard across the wrap
        @(negedge slow_clk);
        ms = sub_cnt; mc = sec_cnt; pend = 1'b0;
        #1;
        for (int i = 0; i < 12; i++) begin
            exp_t e;
            int unsigned ns, nc;
            ns = (ms == SUB_MAX) ? 0 : ms + 1;
            nc = pend ? mc + 1 : mc;
            pend = (ms == SUB_MAX);
            ms = ns; mc = nc;
            e.sub = ms; e.sec = mc;
            e.req = (ms == 0) ? "R3 zero with old seconds" : "R2 R3 counting";
            sb_q.push_back(e);
        end
        wait_slow(13);

        // R4 seconds stopped while subseconds wrap
        wr(3'd0, 32'h1, 7'b0000001);
        wr(3'd3, 32700, 7'b0001000);
        @(negedge slow_clk);
        mc = sec_cnt;
        wait_slow(100);
        check("R4 sec frozen", sec_cnt, mc);
        check("R4 sub wrapped", 32'(sub_cnt < 15'd32700), 1);

        // R6/R9 subsecond match alarm
        wr(3'd0, 32'h0, 7'b0000001);
        wr(3'd3, 10, 7'b0001000);
        wr(3'd1, 40, 7'b0000010);
        wr(3'd0, 32'h5, 7'b0000001);
        rd(3'd6, s); check("R6 no flag before match", 32'(s[8]), 0);
        check("R9 irq low before match", 32'(irq), 0);
        wait_slow(40);
        rd(3'd6, s); check("R6 sub match flag", 32'(s[8]), 1);
        check("R9 irq high", 32'(irq), 1);
        wr(3'd5, 32'h1, 7'b0100000);
        rd(3'd6, s); check("R8 sub flag cleared", 32'(s[8]), 0);
        check("R9 irq low after clear", 32'(irq), 0);

        // R6 enable gating on seconds, R8 set-wins, R9 sticky without enable
        wr(3'd0, 32'h0, 7'b0000001);
        wr(3'd4, 9, 7'b0010000);
        wr(3'd2, 9, 7'b0000100);
        wr(3'd0, 32'h2, 7'b0000001);
        wait_slow(5);
        rd(3'd6, s); check("R6 disabled no sec flag", 32'(s[9]), 0);
        wr(3'd0, 32'hA, 7'b0000001);
        wait_slow(4);
        rd(3'd6, s); check("R6 sec match flag", 32'(s[9]), 1);
        check("R9 irq sec", 32'(irq), 1);
        wr(3'd5, 32'h2, 7'b1000000);
        rd(3'd6, s); check("R8 set wins over clear", 32'(s[9]), 1);
        wr(3'd0, 32'h0, 7'b0000001);
        rd(3'd6, s); check("R9 flag sticky", 32'(s[9]), 1);
        check("R9 irq drops without enable", 32'(irq), 0);
        wr(3'd5, 32'h2, 7'b1000000);
        rd(3'd6, s); check("R8 sec flag cleared", 32'(s[9]), 0);

        // R7 increment mode
        wr(3'd1, 30000, 7'b0000010);
        wr(3'd3, 0, 7'b0001000);
        wr(3'd0, 32'h15, 7'b0000001);
        wait_slow(3);
        rd(3'd6, s); check("R7 sub increment flag", 32'(s[8]), 1);
        check("R7 irq", 32'(irq), 1);
        wr(3'd5, 32'h1, 7'b0100000);
        rd(3'd6, s); check("R8 increment set wins", 32'(s[8]), 1);
        wr(3'd0, 32'h29, 7'b0000001);
        wr(3'd5, 32'h3, 7'b1100000);
        wait_slow(5);
        rd(3'd6, s); check("R7 no flag while sec stopped", 32'(s[9]), 0);
        wr(3'd3, 32765, 7'b0001000);
        wr(3'd0, 32'h2B, 7'b0000001);
        wait_slow(10);
        rd(3'd6, s); check("R7 sec increment flag", 32'(s[9]), 1);

        // R5 zeroing through the control word
        wr(3'd0, 32'h40, 7'b0000001);
        wait_slow(1);
        check("R5 zero sub", 32'(sub_cnt), 0);
        check("R5 zero sec", sec_cnt, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule